// File: doc/BRIEF.md
# Classic Bus Word Memory Target

This block is a small word-addressed storage target for a classic (non-pipelined) Wishbone bus. It waits until an edge on which the master holds both the cycle and strobe lines high. It then decodes the word index from the address and carries out one of two operations on an internal register array. A read returns the whole 64-bit word. A write updates only the byte lanes that the select mask enables.

Each accepted request is answered with a single-cycle acknowledge. After that, the target stays deaf to the bus for a fixed number of idle cycles, one by default, before it samples a new request. Every entry carries a valid flag that reset clears. An entry that has never been written therefore reads as zero, and a partial write to such an entry merges its lanes into zero. The array contents themselves are never reset. The address wraps modulo the array depth. The target never stalls the master and has no error response.

Top module: `wbc_mem_target`

## Requirements
- R1: A request is taken only on a rising edge where the target is idle and `cyc` and `stb` are both high. With either line low, `ack` stays low and the stored data is left unchanged, even if `we` is high.
- R2: A read request places the stored word for the addressed entry on `dat_r`, and `dat_r` is valid in the cycle where `ack` is high.
- R3: On a write, byte lane i (bits 8i+7 down to 8i) takes the matching bits of `dat_w` when `sel[i]` is 1 and keeps its stored byte when `sel[i]` is 0. A write with `sel` equal to 0 leaves the entry unchanged.
- R4: An entry that has not been written since reset reads as zero. A partial write to such an entry stores zero in every unselected lane.
- R5: `ack` rises in the cycle right after the accepting edge and stays high for exactly one cycle.
- R6: After `ack` falls, the target ignores the bus for one cycle. A request held high through that cycle is taken on the following edge, so its `ack` comes three cycles after the previous one.
- R7: The entry index is `adr` modulo DEPTH. Address bits above log2(DEPTH) have no effect.
- R8: `dat_r` holds its value from one read to the next. Write requests and idle cycles leave it unchanged.
- R9: Synchronous reset drives `ack` and `dat_r` to zero and makes every entry read as zero again, including entries written before the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | input | 1 | Bus cycle in progress |
| stb | input | 1 | Request strobe |
| we | input | 1 | 1 = write, 0 = read |
| adr | input | ADR_W (32) | Word index of the addressed entry |
| dat_w | input | DATA_W (64) | Write data |
| sel | input | DATA_W/8 (8) | Byte lane enables for writes |
| dat_r | output | DATA_W (64) | Read data, held between reads |
| ack | output | 1 | One-cycle acknowledge |

## Verification
The bench covers the following corner cases, and each one targets a specific wrong behaviour:
- **Strobe without cycle, or cycle without strobe.** A target that decodes only one of the two lines would write memory or raise an unexpected acknowledge.
- **Request held through the idle gap.** A target without the gap would acknowledge two cycles after the previous `ack` instead of three, or would hold `ack` high for two cycles in a row.
- **Partial writes to unwritten entries, and writes with an empty mask.** These expose a merge that uses stale array contents instead of zero, or one that touches unselected lanes.
- **Aliased addresses, reset between write and read, and a write issued after a read.** A wrong index slice, a valid flag that survives reset, or a `dat_r` that follows writes would each show up as a mismatched read word.

// File: rtl/wbc_mem_pkg.sv
`timescale 1ns/1ps
package wbc_mem_pkg;

   // Handshake phase of the target sequencer.
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_GAP  = 2'd2
   } wbc_phase_e;

   // Index width for an array of d entries (at least one bit).
   function automatic int unsigned idx_bits(input int unsigned d);
      return (d < 2) ? 1 : $clog2(d);
   endfunction

endpackage

// File: rtl/wbc_lane_merge.sv
`timescale 1ns/1ps
module wbc_lane_merge #(
   parameter int unsigned LANE_W = 8,
   parameter int unsigned LANES  = 8
) (
   input  logic [LANE_W*LANES-1:0] old_word,
   input  logic [LANE_W*LANES-1:0] new_word,
   input  logic [LANES-1:0]        lane_en,
   output logic [LANE_W*LANES-1:0] merged
);

   if (LANE_W == 0 || LANES == 0) begin : g_bad_shape
      $error("wbc_lane_merge: LANE_W and LANES must be nonzero");
   end

   // One multiplexer per byte lane: new byte when enabled, old byte otherwise.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign merged[g*LANE_W +: LANE_W] =
         lane_en[g] ? new_word[g*LANE_W +: LANE_W] : old_word[g*LANE_W +: LANE_W];
   end

endmodule

// File: rtl/wbc_store.sv
`timescale 1ns/1ps
module wbc_store #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wr_word,
   output logic [DATA_W-1:0] old_word,
   output logic [DATA_W-1:0] rd_data
);

   if ((1 << IDX_W) != DEPTH) begin : g_bad_idx
      $error("wbc_store: IDX_W must match a power-of-two DEPTH");
   end

   logic [DATA_W-1:0] cell_q [DEPTH];
   logic [DEPTH-1:0]  live_q;

   // Entries without a live flag present zero, both to reads and to the merge.
   assign old_word = live_q[idx] ? cell_q[idx] : '0;

   // Data cells carry no reset; only the live flags are cleared.
   always_ff @(posedge clk) begin
      if (wr_en) cell_q[idx] <= wr_word;
   end

   always_ff @(posedge clk) begin
      if (rst)        live_q      <= '0;
      else if (wr_en) live_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)        rd_data <= '0;
      else if (rd_en) rd_data <= old_word;
   end

   // A written entry is live from the next cycle on.
   assert_write_marks_live_R4: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> live_q[$past(idx)]);

   // Leaving reset, no entry is live.
   assert_reset_clears_live_R9: assert property (@(posedge clk)
      $fell(rst) |-> (live_q == '0));

   // A read and a write never share one edge.
   assert_single_op_R1: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && rd_en));

endmodule

// File: rtl/wbc_seq.sv
`timescale 1ns/1ps
module wbc_seq
   import wbc_mem_pkg::*;
#(
   parameter int unsigned GAP_CYC = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic cyc,
   input  logic stb,
   output logic take,
   output logic ack
);

   localparam int unsigned GW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);

   if (GAP_CYC < 1) begin : g_bad_gap
      $error("wbc_seq: GAP_CYC must be at least 1");
   end

   wbc_phase_e    phase_q;
   logic [GW-1:0] gap_q;

   assign take = (phase_q == ST_IDLE) && cyc && stb;
   assign ack  = (phase_q == ST_ACK);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= ST_IDLE;
         gap_q   <= '0;
      end else begin
         unique case (phase_q)
            ST_IDLE: if (take) phase_q <= ST_ACK;
            ST_ACK: begin
               phase_q <= ST_GAP;
               gap_q   <= GW'(GAP_CYC - 1);
            end
            ST_GAP: begin
               if (gap_q == '0) phase_q <= ST_IDLE;
               else             gap_q   <= gap_q - 1'b1;
            end
            default: phase_q <= ST_IDLE;
         endcase
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
      (phase_q == ST_IDLE && !(cyc && stb)) |=> !ack);

   assert_take_acks_R5: assert property (@(posedge clk) disable iff (rst)
      take |=> ack);

   assert_ack_single_R5: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);

   assert_gap_low_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(ack) |=> !ack);

   assert_gap_no_take_R6: assert property (@(posedge clk) disable iff (rst)
      $fell(ack) |-> !take);

endmodule

// File: rtl/wbc_mem_target.sv
`timescale 1ns/1ps
module wbc_mem_target #(
   parameter int unsigned DATA_W  = 64,
   parameter int unsigned ADR_W   = 32,
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned GAP_CYC = 1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                cyc,
   input  logic                stb,
   input  logic                we,
   input  logic [ADR_W-1:0]    adr,
   input  logic [DATA_W-1:0]   dat_w,
   input  logic [DATA_W/8-1:0] sel,
   output logic [DATA_W-1:0]   dat_r,
   output logic                ack
);

   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned IDX_W = wbc_mem_pkg::idx_bits(DEPTH);

   if (DATA_W == 0 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("wbc_mem_target: DATA_W must be a nonzero multiple of 8");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("wbc_mem_target: DEPTH must be a power of two, at least 2");
   end
   if (IDX_W > ADR_W) begin : g_bad_adr
      $error("wbc_mem_target: ADR_W too narrow for DEPTH");
   end

   logic             take;
   logic             wr_take;
   logic             rd_take;
   logic [IDX_W-1:0] row;
   logic [DATA_W-1:0] old_word;
   logic [DATA_W-1:0] new_word;

   // Index wraps modulo the depth.
   assign row     = IDX_W'(adr % ADR_W'(DEPTH));
   assign wr_take = take && we;
   assign rd_take = take && !we;

   wbc_seq #(
      .GAP_CYC (GAP_CYC)
   ) seq_i (
      .clk  (clk),
      .rst  (rst),
      .cyc  (cyc),
      .stb  (stb),
      .take (take),
      .ack  (ack)
   );

   wbc_lane_merge #(
      .LANE_W (8),
      .LANES  (LANES)
   ) merge_i (
      .old_word (old_word),
      .new_word (dat_w),
      .lane_en  (sel),
      .merged   (new_word)
   );

   wbc_store #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W)
   ) store_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_take),
      .rd_en    (rd_take),
      .idx      (row),
      .wr_word  (new_word),
      .old_word (old_word),
      .rd_data  (dat_r)
   );

   assert_read_acks_R2: assert property (@(posedge clk) disable iff (rst)
      rd_take |=> ack);

   assert_hold_rdata_R8: assert property (@(posedge clk) disable iff (rst)
      !rd_take |=> $stable(dat_r));

   assert_empty_mask_keeps_R3: assert property (@(posedge clk) disable iff (rst)
      (wr_take && sel == '0) |-> (new_word == old_word));

endmodule

// File: tb/wbc_mem_target_tb_top.sv
`timescale 1ns/1ps
module wbc_mem_target_tb_top;

   localparam int unsigned DW = 64;
   localparam int unsigned AW = 32;
   localparam int unsigned DP = 16;

   typedef struct {
      bit          rd;
      logic [63:0] data;
      string       tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cyc = 1'b0;
   logic          stb = 1'b0;
   logic          we  = 1'b0;
   logic [AW-1:0] adr = '0;
   logic [DW-1:0] dat_w = '0;
   logic [7:0]    sel = '0;
   logic [DW-1:0] dat_r;
   logic          ack;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   exp_t sb_q[$];

   logic [63:0] mdl  [DP];
   bit          mlive[DP];

   always #5 clk = ~clk;

   wbc_mem_target #(
      .DATA_W (DW), .ADR_W (AW), .DEPTH (DP), .GAP_CYC (1)
   ) dut_i (
      .clk (clk), .rst (rst), .cyc (cyc), .stb (stb), .we (we),
      .adr (adr), .dat_w (dat_w), .sel (sel), .dat_r (dat_r), .ack (ack)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Expected result of a request, built from the lane and zero-fill rules.
   task automatic push_exp(input bit w, input logic [AW-1:0] a,
                           input logic [63:0] d, input logic [7:0] s,
                           input string tag);
      int unsigned i;
      logic [63:0] cur;
      exp_t e;
      i   = a % DP;
      cur = mlive[i] ? mdl[i] : 64'd0;
      if (w) begin
         for (int b = 0; b < 8; b++)
            if (s[b]) cur[b*8 +: 8] = d[b*8 +: 8];
         mdl[i]   = cur;
         mlive[i] = 1'b1;
      end
      e.rd = !w; e.data = cur; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Driver: called right after a falling edge; leaves the bus idle and ready.
   task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [63:0] d,
                       input logic [7:0] s, input string tag);
      push_exp(w, a, d, s, tag);
      cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_w = d; sel = s;
      @(negedge clk);
      chk(ack === 1'b1, {"R5 ack one cycle after take ", tag}, 64'(ack), 64'd1);
      cyc = 1'b0; stb = 1'b0; we = 1'b0;
      @(negedge clk);
      chk(ack === 1'b0, {"R5 ack single pulse ", tag}, 64'(ack), 64'd0);
      @(negedge clk);
   endtask

   // Monitor: pop the scoreboard on every ack and compare read words.
   bit ack_prev = 1'b0;
   always @(negedge clk) begin
      if (!rst) begin
         if (ack && ack_prev) begin
            n_cmp++; n_bad++;
            $display("FAIL R5: ack high two cycles, actual 1 expected 0");
         end
         if (ack) begin
            if (sb_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R1: unexpected ack, actual 1 expected 0");
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               if (e.rd) chk(dat_r === e.data, {"R2 read word ", e.tag}, dat_r, e.data);
            end
         end
      end
      ack_prev = ack;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      finish_run();
   end

   initial begin
      for (int i = 0; i < DP; i++) begin mdl[i] = '0; mlive[i] = 1'b0; end
      repeat (2) @(negedge clk);
      chk(ack === 1'b0, "R9 ack zero in reset", 64'(ack), 64'd0);
      chk(dat_r === 64'd0, "R9 dat_r zero in reset", dat_r, 64'd0);
      rst = 1'b0;
      @(negedge clk);

      // R4: unwritten entry and partial write into zero
      xfer(1'b0, 32'd5, 64'd0, 8'h00, "R4 unwritten reads zero");
      xfer(1'b1, 32'd5, 64'h1122334455667788, 8'h0F, "R4 partial into zero");
      xfer(1'b0, 32'd5, 64'd0, 8'h00, "R4 merged with zero");
      // R3: sparse lanes and empty mask
      xfer(1'b1, 32'd5, 64'hAABBCCDDEEFF0011, 8'hA0, "R3 lanes 5 and 7");
      xfer(1'b0, 32'd5, 64'd0, 8'h00, "R3 sparse merge");
      xfer(1'b1, 32'd5, 64'hFFFFFFFFFFFFFFFF, 8'h00, "R3 empty mask");
      xfer(1'b0, 32'd5, 64'd0, 8'h00, "R3 empty mask kept");
      // R7: aliasing above the depth
      xfer(1'b1, 32'd9, 64'h0123456789ABCDEF, 8'hFF, "R7 full write");
      xfer(1'b0, 32'd25, 64'd0, 8'h00, "R7 alias 25 to 9");
      xfer(1'b1, 32'h8000_0008, 64'hDEADBEEFCAFEF00D, 8'hFF, "R7 high bit write");
      xfer(1'b0, 32'd8, 64'd0, 8'h00, "R7 alias to 8");
      // fill and read back every entry with varied masks
      for (int i = 0; i < DP; i++)
         xfer(1'b1, AW'(i), {8{8'(i * 17 + 3)}}, 8'(8'h5A ^ (i * 8'h11)), "R3 sweep write");
      for (int i = 0; i < DP; i++)
         xfer(1'b0, AW'(i + DP * 3), 64'd0, 8'h00, "R2 sweep read");

      // R8: dat_r survives a later write and idle cycles
      begin
         logic [63:0] held;
         xfer(1'b0, 32'd9, 64'd0, 8'h00, "R8 read first");
         held = mlive[9] ? mdl[9] : 64'd0;
         xfer(1'b1, 32'd2, 64'h5555AAAA5555AAAA, 8'hFF, "R8 write after read");
         chk(dat_r === held, "R8 dat_r held across write", dat_r, held);
         repeat (3) @(negedge clk);
         chk(dat_r === held, "R8 dat_r held while idle", dat_r, held);
      end

      // R1: one line low means no request and no write
      cyc = 1'b1; stb = 1'b0; we = 1'b1; adr = 32'd3; dat_w = '1; sel = 8'hFF;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(ack === 1'b0, "R1 cyc without stb", 64'(ack), 64'd0);
      end
      cyc = 1'b0; stb = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(ack === 1'b0, "R1 stb without cyc", 64'(ack), 64'd0);
      end
      stb = 1'b0; we = 1'b0;
      @(negedge clk);
      xfer(1'b0, 32'd3, 64'd0, 8'h00, "R1 entry untouched");

      // R6: request held through the gap is taken one cycle late
      push_exp(1'b0, 32'd5, 64'd0, 8'h00, "R6 first");
      cyc = 1'b1; stb = 1'b1; we = 1'b0; adr = 32'd5;
      @(negedge clk);
      chk(ack === 1'b1, "R6 first ack", 64'(ack), 64'd1);
      push_exp(1'b0, 32'd9, 64'd0, 8'h00, "R6 second");
      adr = 32'd9;
      @(negedge clk);
      chk(ack === 1'b0, "R6 ack low after pulse", 64'(ack), 64'd0);
      @(negedge clk);
      chk(ack === 1'b0, "R6 held request ignored in gap", 64'(ack), 64'd0);
      @(negedge clk);
      chk(ack === 1'b1, "R6 second ack three cycles later", 64'(ack), 64'd1);
      cyc = 1'b0; stb = 1'b0;
      repeat (2) @(negedge clk);

      // R9: reset forgets earlier writes
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk(ack === 1'b0, "R9 ack zero in second reset", 64'(ack), 64'd0);
      chk(dat_r === 64'd0, "R9 dat_r cleared", dat_r, 64'd0);
      for (int i = 0; i < DP; i++) mlive[i] = 1'b0;
      rst = 1'b0;
      @(negedge clk);
      xfer(1'b0, 32'd9, 64'd0, 8'h00, "R9 written entry reads zero");
      xfer(1'b1, 32'd9, 64'h00000000000000C3, 8'h01, "R9 partial after reset");
      xfer(1'b0, 32'd9, 64'd0, 8'h00, "R9 merge with zero after reset");

      repeat (2) @(negedge clk);
      chk(sb_q.size() == 0, "R5 every request acknowledged", 64'(sb_q.size()), 64'd0);
      finish_run();
   end

endmodule